// File: doc/BRIEF.md
# Uncorrectable Error Register Set

This block holds the software-visible record of uncorrectable errors for a PCI Express endpoint. The link and transaction logic report each error class as a one-cycle pulse on its own bit of an event vector. The block latches the pulse into a sticky status bit, which software clears by writing one to it. A mask register and a severity register sit beside the status register. Together the three decide whether a pending error asks for a fatal or a non-fatal error message.

Software reaches the three 32-bit registers over a simple register bus. The bus has a 12-bit address, a write strobe with byte enables, and a read strobe. Read data appears one cycle after the read strobe. Every bit position has a fixed access type. Some positions are reserved, some are hardwired, and one status bit is plain storage. Those rules are fixed in a shared package, so decode and behaviour cannot drift apart.

Top module: `pcie_uerr_regs`

## Requirements
- R1: A read strobe at 0x104 (status), 0x108 (mask) or 0x10C (severity) returns that register on `reg_rdata` in the cycle after the strobe. In a cycle after no read strobe, `reg_rdata` is zero.
- R2: Status bits 4, 5, 12, 14, 15, 16, 18, 19 and 20 set when the event input of the same index pulses high. They clear only when software writes a one to them. Writing zero leaves them unchanged.
- R3: Bits 31:21, 11:6 and 3:1 read as zero in all three registers, whatever was written or signalled.
- R4: Status bit 17 always reads zero and ignores its event input. Mask bit 17 and severity bit 17 are ordinary read/write bits.
- R5: Bit 13 cannot be written or set. It reads 0 in status and mask and reads 1 in severity.
- R6: Status bit 0 is plain read/write storage and resets to 0. Writing 0 clears it, writing 1 sets it, and its event input is ignored.
- R7: After reset, status reads 0x0000_0000, mask reads 0x0000_0000 and severity reads 0x0006_2031.
- R8: Mask and severity store written data at bit positions 0, 4, 5, 12, 14 to 20 (read/write).
- R9: When an event pulse and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R10: `fatal_req` is high while some status bit is set with mask 0 and severity 1. `nonfatal_req` is high while some status bit is set with mask 0 and severity 0. Both follow register state one cycle after the event or write.
- R11: A write changes only bytes whose `reg_be` bit is 1, where `reg_be[k]` covers data bits 8k+7:8k.
- R12: Writes to any address other than the three offsets change nothing, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for the write |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| err_evt | input | 32 | One-cycle error pulses, one per status bit position |
| fatal_req | output | 1 | Unmasked error of fatal severity pending |
| nonfatal_req | output | 1 | Unmasked error of non-fatal severity pending |

## Verification
The bench walks every one of the 32 bit positions. At each one it pulses the event, reads status back, writes one to clear it, and reads again. A wrong access map shows up as a reserved or hardwired bit that latches. It also shows up as bit 0 that clears on a write of one instead of being set by it. The bench fires an event and a clear together on one bit to catch a design that lets the clear win. It sweeps all sixteen byte-enable patterns to catch a write that ignores the byte lanes. It tries every mask/severity combination on each error bit to catch a swapped or inverted request rule. Writes and reads at addresses next to the map catch partial address decode.

// File: rtl/uerr_pkg.sv
package uerr_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned BW = DW / 8;

    // status positions that latch events and clear on write-one
    localparam logic [DW-1:0] STS_STICKY  = 32'h001D_D030;
    // status positions that are plain storage
    localparam logic [DW-1:0] STS_PLAIN   = 32'h0000_0001;
    // mask / severity storage positions
    localparam logic [DW-1:0] CFG_STORE   = 32'h001F_D031;
    // severity position hardwired to one
    localparam logic [DW-1:0] SEV_TIED    = 32'h0000_2000;
    localparam logic [DW-1:0] SEV_RESET   = 32'h0006_2031;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_MASK,
        SEL_SEVERITY
    } reg_sel_e;

endpackage

// File: rtl/uerr_status_reg.sv
module uerr_status_reg
    import uerr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] lane_bits,
    input  logic [DW-1:0] evt,
    output logic [DW-1:0] sts_val
);

    logic [DW-1:0] sts_q;
    logic [DW-1:0] sts_d;
    logic [DW-1:0] clr_bits;
    logic [DW-1:0] set_bits;
    logic [DW-1:0] plain_we;

    always_comb begin
        clr_bits = wr_en ? (wdata & lane_bits & STS_STICKY) : '0;
        set_bits = evt & STS_STICKY;
        plain_we = wr_en ? (lane_bits & STS_PLAIN) : '0;
        sts_d    = (((sts_q & ~clr_bits) | set_bits) & STS_STICKY)
                 | (((sts_q & ~plain_we) | (wdata & plain_we)) & STS_PLAIN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts_val = sts_q & (STS_STICKY | STS_PLAIN);

endmodule

// File: rtl/uerr_cfg_reg.sv
module uerr_cfg_reg
    import uerr_pkg::*;
#(
    parameter logic [DW-1:0] STORE_BITS = CFG_STORE,
    parameter logic [DW-1:0] RESET_VAL  = '0,
    parameter logic [DW-1:0] TIED_ONES  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] lane_bits,
    output logic [DW-1:0] cfg_val
);

    localparam logic [DW-1:0] INIT_Q = RESET_VAL & STORE_BITS;

    logic [DW-1:0] cfg_q;
    logic [DW-1:0] we_bits;

    assign we_bits = wr_en ? (lane_bits & STORE_BITS) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= INIT_Q;
        end else begin
            cfg_q <= (cfg_q & ~we_bits) | (wdata & we_bits);
        end
    end

    assign cfg_val = (cfg_q & STORE_BITS) | TIED_ONES;

endmodule

// File: rtl/uerr_req_merge.sv
module uerr_req_merge
    import uerr_pkg::*;
(
    input  logic [DW-1:0] sts_val,
    input  logic [DW-1:0] msk_val,
    input  logic [DW-1:0] sev_val,
    output logic          fatal_req,
    output logic          nonfatal_req
);

    logic [DW-1:0] live;

    assign live         = sts_val & ~msk_val;
    assign fatal_req    = |(live & sev_val);
    assign nonfatal_req = |(live & ~sev_val);

endmodule

// File: rtl/pcie_uerr_regs.sv
module pcie_uerr_regs
    import uerr_pkg::*;
#(
    parameter int unsigned         ADDR_W  = 12,
    parameter logic [ADDR_W-1:0]   STS_OFS = 12'h104,
    parameter logic [ADDR_W-1:0]   MSK_OFS = 12'h108,
    parameter logic [ADDR_W-1:0]   SEV_OFS = 12'h10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [BW-1:0]     reg_be,
    input  logic              reg_rd,
    output logic [DW-1:0]     reg_rdata,
    input  logic [DW-1:0]     err_evt,
    output logic              fatal_req,
    output logic              nonfatal_req
);

    reg_sel_e      sel;
    logic [DW-1:0] lane_bits;
    logic [DW-1:0] sts_val;
    logic [DW-1:0] msk_val;
    logic [DW-1:0] sev_val;
    logic [DW-1:0] rd_mux;

    for (genvar g = 0; g < BW; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{reg_be[g]}};
    end

    always_comb begin
        if (reg_addr == STS_OFS) begin
            sel = SEL_STATUS;
        end else if (reg_addr == MSK_OFS) begin
            sel = SEL_MASK;
        end else if (reg_addr == SEV_OFS) begin
            sel = SEL_SEVERITY;
        end else begin
            sel = SEL_NONE;
        end
    end

    uerr_status_reg u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && (sel == SEL_STATUS)),
        .wdata     (reg_wdata),
        .lane_bits (lane_bits),
        .evt       (err_evt),
        .sts_val   (sts_val)
    );

    uerr_cfg_reg #(
        .STORE_BITS (CFG_STORE),
        .RESET_VAL  ('0),
        .TIED_ONES  ('0)
    ) u_msk (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && (sel == SEL_MASK)),
        .wdata     (reg_wdata),
        .lane_bits (lane_bits),
        .cfg_val   (msk_val)
    );

    uerr_cfg_reg #(
        .STORE_BITS (CFG_STORE),
        .RESET_VAL  (SEV_RESET),
        .TIED_ONES  (SEV_TIED)
    ) u_sev (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && (sel == SEL_SEVERITY)),
        .wdata     (reg_wdata),
        .lane_bits (lane_bits),
        .cfg_val   (sev_val)
    );

    uerr_req_merge u_merge (
        .sts_val      (sts_val),
        .msk_val      (msk_val),
        .sev_val      (sev_val),
        .fatal_req    (fatal_req),
        .nonfatal_req (nonfatal_req)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS:   rd_mux = sts_val;
            SEL_MASK:     rd_mux = msk_val;
            SEL_SEVERITY: rd_mux = sev_val;
            SEL_NONE:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= reg_rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/uerr_regs_checker.sv
module uerr_regs_checker
    import uerr_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] STS_OFS = 12'h104,
    parameter logic [ADDR_W-1:0] SEV_OFS = 12'h10C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DW-1:0]     reg_wdata,
    input logic [BW-1:0]     reg_be,
    input logic              reg_rd,
    input logic [DW-1:0]     reg_rdata,
    input logic [DW-1:0]     err_evt,
    input logic              fatal_req,
    input logic              nonfatal_req,
    input logic [DW-1:0]     sts_val,
    input logic [DW-1:0]     msk_val
);

    localparam logic [DW-1:0] RSVD = 32'hFFE0_0FCE;

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & RSVD) == '0); // R3

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> reg_rdata == '0); // R1

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt & STS_STICKY) != '0
        |=> (sts_val & $past(err_evt & STS_STICKY)) == $past(err_evt & STS_STICKY)); // R9

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == STS_OFS && reg_be == '1 && (err_evt & STS_STICKY) == '0)
        |=> (sts_val & $past(reg_wdata) & STS_STICKY) == '0); // R2

    AST_SEV_TIED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == SEV_OFS) |=> reg_rdata[13]); // R5

    AST_NO_REQ_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_val & ~msk_val) == '0 |-> (!fatal_req && !nonfatal_req)); // R10

endmodule

bind pcie_uerr_regs uerr_regs_checker #(
    .ADDR_W  (ADDR_W),
    .STS_OFS (STS_OFS),
    .SEV_OFS (SEV_OFS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_be       (reg_be),
    .reg_rd       (reg_rd),
    .reg_rdata    (reg_rdata),
    .err_evt      (err_evt),
    .fatal_req    (fatal_req),
    .nonfatal_req (nonfatal_req),
    .sts_val      (sts_val),
    .msk_val      (msk_val)
);

// File: tb/pcie_uerr_regs_bench.sv
module pcie_uerr_regs_bench;

    localparam logic [11:0] A_STS = 12'h104;
    localparam logic [11:0] A_MSK = 12'h108;
    localparam logic [11:0] A_SEV = 12'h10C;
    localparam logic [31:0] W1C   = 32'h001D_D030;
    localparam logic [31:0] CFGRW = 32'h001F_D031;
    localparam logic [31:0] SEVRS = 32'h0006_2031;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [31:0] err_evt = '0;
    logic        fatal_req;
    logic        nonfatal_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcie_uerr_regs u_pcie_uerr_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_be       (reg_be),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .err_evt      (err_evt),
        .fatal_req    (fatal_req),
        .nonfatal_req (nonfatal_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        err_evt = v;
        @(negedge clk);
        err_evt = '0;
    endtask

    function automatic string bit_tag(input int b);
        if (b == 13) return "R5 bit13";
        if (b == 17) return "R4 bit17";
        if (b == 0)  return "R6 bit0";
        if (W1C[b])  return "R2 sticky";
        return "R3 reserved";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset values
        rd(A_STS, d); check("R7 status reset", d, 32'h0);
        rd(A_MSK, d); check("R7 mask reset", d, 32'h0);
        rd(A_SEV, d); check("R7 severity reset", d, SEVRS);
        // R1 idle read is zero
        @(negedge clk); check("R1 idle rdata", reg_rdata, 32'h0);

        // sweep every bit: event, then write-one
        for (int b = 0; b < 32; b++) begin
            logic [31:0] one;
            one = 32'h1 << b;
            pulse(one);
            rd(A_STS, d); check(bit_tag(b), d, one & W1C);
            wr(A_STS, 32'h0, 4'hF);
            rd(A_STS, d); check({bit_tag(b), " write0 keeps"}, d, one & W1C);
            wr(A_STS, one, 4'hF);
            rd(A_STS, d); check({bit_tag(b), " write1"}, d, one & 32'h1);
            wr(A_STS, 32'h0, 4'hF);
        end
        rd(A_STS, d); check("R6 bit0 cleared by 0", d, 32'h0);

        // R8 R5 R3 mask/severity storage
        wr(A_MSK, 32'hFFFF_FFFF, 4'hF); rd(A_MSK, d); check("R8 mask ones", d, CFGRW);
        wr(A_SEV, 32'hFFFF_FFFF, 4'hF); rd(A_SEV, d); check("R8 sev ones", d, CFGRW | 32'h2000);
        wr(A_MSK, 32'h0, 4'hF); rd(A_MSK, d); check("R5 mask zeros", d, 32'h0);
        wr(A_SEV, 32'h0, 4'hF); rd(A_SEV, d); check("R5 sev bit13 tied", d, 32'h2000);
        wr(A_SEV, 32'h000A_5010, 4'hF); rd(A_SEV, d); check("R4 sev pattern", d, (32'h000A_5010 & CFGRW) | 32'h2000);

        // R11 byte enables
        for (int be = 0; be < 16; be++) begin
            logic [31:0] lm;
            lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            wr(A_MSK, 32'h0, 4'hF);
            wr(A_MSK, 32'hFFFF_FFFF, 4'(be));
            rd(A_MSK, d); check("R11 byte lanes", d, CFGRW & lm);
        end
        wr(A_MSK, 32'h0, 4'hF);

        // R9 event and clear in the same cycle
        pulse(32'h0000_0010);
        @(negedge clk);
        reg_addr = A_STS; reg_wdata = 32'h0010_0010; reg_be = 4'hF; reg_wr = 1'b1;
        err_evt = 32'h0010_0000;
        @(negedge clk);
        reg_wr = 1'b0; err_evt = '0;
        rd(A_STS, d); check("R9 set wins over clear", d, 32'h0010_0000);
        wr(A_STS, W1C, 4'hF);
        rd(A_STS, d); check("R2 clear all", d, 32'h0);

        // R10 request rule for every sticky bit and mask/severity pair
        for (int b = 0; b < 32; b++) begin
            if (W1C[b]) begin
                for (int c = 0; c < 4; c++) begin
                    logic [31:0] one;
                    one = 32'h1 << b;
                    wr(A_MSK, c[0] ? one : 32'h0, 4'hF);
                    wr(A_SEV, c[1] ? one : 32'h0, 4'hF);
                    pulse(one);
                    check("R10 fatal", {31'h0, fatal_req}, {31'h0, !c[0] && c[1]});
                    check("R10 nonfatal", {31'h0, nonfatal_req}, {31'h0, !c[0] && !c[1]});
                    wr(A_STS, one, 4'hF);
                    check("R10 quiet after clear", {30'h0, fatal_req, nonfatal_req}, 32'h0);
                end
            end
        end
        // bit0 storage also drives a request (severity bit0 written 1)
        wr(A_MSK, 32'h0, 4'hF);
        wr(A_SEV, 32'h1, 4'hF);
        wr(A_STS, 32'h1, 4'h1);
        check("R6 R10 bit0 fatal", {31'h0, fatal_req}, 32'h1);
        wr(A_STS, 32'h0, 4'h1);

        // R12 unmapped addresses
        wr(A_MSK, 32'h0000_1030, 4'hF);
        wr(12'h100, 32'hFFFF_FFFF, 4'hF);
        wr(12'h110, 32'hFFFF_FFFF, 4'hF);
        wr(12'h109, 32'hFFFF_FFFF, 4'hF);
        wr(12'h508, 32'hFFFF_FFFF, 4'hF);
        rd(12'h109, d); check("R12 unmapped read", d, 32'h0);
        rd(12'h508, d); check("R12 alias read", d, 32'h0);
        rd(A_MSK, d); check("R12 mask untouched", d, 32'h0000_1030);
        rd(A_STS, d); check("R12 status untouched", d, 32'h0);
        rd(A_SEV, d); check("R12 sev untouched", d, 32'h0000_2001);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule